// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number and an offset within that segment, into a flat physical address. It looks the segment up in a small table of registers held inside the block and indexed directly by segment number. Each table entry describes one segment: where it starts in physical memory, how long it is, whether it is usable at all, and which kinds of access (read, write, fetch for execution) it allows. A separate register says how many segments the current process owns. Privileged software fills the entries and that count through a plain configuration port before it starts issuing translations.

Every request passes a fixed chain of checks, and the first check that fails decides the fault code. The order is: segment count, validity, offset against length, access permission. A request that passes them all gets back the segment base plus the offset. Requests come in on a valid/ready stream and responses leave on another. There is one register stage between them. A response that the consumer has not yet taken is held unchanged. While it is held, no new request is accepted: `req_ready` equals `!rsp_valid || rsp_ready`.

Top module: `seg_xlate_top`

## Requirements
- R1: When every check passes, `rsp_fault` is 0 and `rsp_paddr` equals the entry base plus the zero-extended offset, modulo 2^PA_W.
- R2: A segment number not less than the segment-count register gives fault code 1.
- R3: A segment whose entry has its valid flag clear gives fault code 2.
- R4: An offset not less than the entry length gives fault code 3. A length of 0 describes an empty segment that faults on every offset.
- R5: Access codes are 0 read, 1 write, 2 execute and 3 reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. A code whose bit is clear gives fault code 4. The reserved code is never allowed.
- R6: When several checks fail, the reported code is the lowest-numbered one in the order 1, 2, 3, 4, and no other code value ever appears.
- R7: A response with a nonzero fault code carries `rsp_paddr` equal to 0.
- R8: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response is presented with `rsp_valid` high from the very next cycle.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay stable and `req_ready` is low. `req_ready` is `!rsp_valid || rsp_ready`.
- R10: After reset `rsp_valid` is low and the segment count is 0, so every request faults with code 1 until software writes the count.
- R11: A configuration write takes effect from the following cycle. A request taken on the same edge is translated with the table contents from before the write. With `cfg_sel` = 0 the write sets one entry; with `cfg_sel` = 1 it sets the segment count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: write entry `cfg_idx`; 1: write segment count |
| cfg_idx | input | SEG_W | Entry being written |
| cfg_base | input | PA_W | Segment start address |
| cfg_len | input | OFF_W+1 | Segment length in bytes |
| cfg_valid | input | 1 | Entry usable flag |
| cfg_perm | input | 3 | Permission bits {exec, write, read} |
| cfg_count | input | SEG_W+1 | Number of segments owned |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access type code |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 3 | Fault code, 0 on success |

## Verification
The hardest situation to reach is a configuration write that lands on the same clock edge as an accepted request for the entry being rewritten. The bench drives both in one cycle. It expects the old translation, then sends a second request that must see the new entry. The second hard case is back-pressure with a new request already waiting behind the held response. The bench holds `rsp_ready` low for several cycles while it offers a different request. It then checks that the held response did not move and that the waiting request is accepted only on the edge where the held response is released.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef logic [2:0] fault_t;
  typedef logic [1:0] acc_t;

  localparam fault_t FLT_NONE   = 3'd0;
  localparam fault_t FLT_RANGE  = 3'd1;
  localparam fault_t FLT_INVAL  = 3'd2;
  localparam fault_t FLT_LENGTH = 3'd3;
  localparam fault_t FLT_PERM   = 3'd4;

  localparam acc_t ACC_READ  = 2'd0;
  localparam acc_t ACC_WRITE = 2'd1;
  localparam acc_t ACC_EXEC  = 2'd2;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
endpackage

// File: rtl/seg_table_regs.sv
module seg_table_regs #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 8,
  parameter int PA_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [SEG_W-1:0] idx,
  input  logic [PA_W-1:0]  wbase,
  input  logic [OFF_W:0]   wlen,
  input  logic             wvalid,
  input  logic [2:0]       wperm,
  input  logic [SEG_W:0]   wcount,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W:0]   rd_len,
  output logic             rd_valid,
  output logic [2:0]       rd_perm,
  output logic [SEG_W:0]   count
);
  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0] base_q  [NSEG];
  logic [OFF_W:0]  len_q   [NSEG];
  logic            valid_q [NSEG];
  logic [2:0]      perm_q  [NSEG];

  // One register set per entry; entries are written one at a time.
  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        len_q[g]   <= '0;
        valid_q[g] <= 1'b0;
        perm_q[g]  <= '0;
      end else if (we && !sel && idx == SEG_W'(g)) begin
        base_q[g]  <= wbase;
        len_q[g]   <= wlen;
        valid_q[g] <= wvalid;
        perm_q[g]  <= wperm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (we && sel)
      count <= wcount;
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_len   = len_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_perm  = perm_q[rd_idx];
endmodule

// File: rtl/seg_check_chain.sv
module seg_check_chain
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 8,
  parameter int PA_W  = 12
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  acc_t             acc,
  input  logic [SEG_W:0]   count,
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W:0]   len,
  input  logic             valid,
  input  logic [2:0]       perm,
  output fault_t           fault,
  output logic [PA_W-1:0]  paddr
);
  localparam int EXT_W = PA_W - OFF_W;

  logic in_range, in_len, allowed;

  assign in_range = {1'b0, seg} < count;
  assign in_len   = {1'b0, off} < len;

  always_comb begin
    case (acc)
      ACC_READ:  allowed = perm[PERM_RD];
      ACC_WRITE: allowed = perm[PERM_WR];
      ACC_EXEC:  allowed = perm[PERM_EX];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    fault = FLT_NONE;
    paddr = '0;
    if (!in_range)      fault = FLT_RANGE;
    else if (!valid)    fault = FLT_INVAL;
    else if (!in_len)   fault = FLT_LENGTH;
    else if (!allowed)  fault = FLT_PERM;
    else                paddr = base + {{EXT_W{1'b0}}, off};
  end
endmodule

// File: rtl/seg_resp_stage.sv
module seg_resp_stage
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  fault_t          in_fault,
  input  logic [PA_W-1:0] in_paddr,
  output logic            out_valid,
  input  logic            out_ready,
  output fault_t          out_fault,
  output logic [PA_W-1:0] out_paddr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= FLT_NONE;
      out_paddr <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fault <= in_fault;
        out_paddr <= in_paddr;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 8,
  parameter int PA_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFF_W:0]   cfg_len,
  input  logic             cfg_valid,
  input  logic [2:0]       cfg_perm,
  input  logic [SEG_W:0]   cfg_count,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_fault
);
  logic [PA_W-1:0] ent_base;
  logic [OFF_W:0]  ent_len;
  logic            ent_valid;
  logic [2:0]      ent_perm;
  logic [SEG_W:0]  seg_count;
  fault_t          chk_fault;
  logic [PA_W-1:0] chk_paddr;

  seg_table_regs #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .idx      (cfg_idx),
    .wbase    (cfg_base),
    .wlen     (cfg_len),
    .wvalid   (cfg_valid),
    .wperm    (cfg_perm),
    .wcount   (cfg_count),
    .rd_idx   (req_seg),
    .rd_base  (ent_base),
    .rd_len   (ent_len),
    .rd_valid (ent_valid),
    .rd_perm  (ent_perm),
    .count    (seg_count)
  );

  seg_check_chain #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk_chain (
    .seg   (req_seg),
    .off   (req_off),
    .acc   (req_acc),
    .count (seg_count),
    .base  (ent_base),
    .len   (ent_len),
    .valid (ent_valid),
    .perm  (ent_perm),
    .fault (chk_fault),
    .paddr (chk_paddr)
  );

  seg_resp_stage #(.PA_W(PA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_fault  (chk_fault),
    .in_paddr  (chk_paddr),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_fault (rsp_fault),
    .out_paddr (rsp_paddr)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [2:0]       rsp_fault,
  input logic [SEG_W:0]   seg_count
);
  assert_fault_zero_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == '0);

  assert_fault_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= 3'd4);

  assert_one_cycle_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && {1'b0, req_seg} >= seg_count) |=> rsp_fault == 3'd1);

  assert_reset_idle_R10: assert property (@(posedge clk)
    $rose(rst_n) |-> !rsp_valid);
endmodule

bind seg_xlate_top seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_seg   (req_seg),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .seg_count (seg_count)
);

// File: tb/seg_xlate_top_tb.sv
module seg_xlate_top_tb;
  localparam int SEG_W = 3;
  localparam int OFF_W = 8;
  localparam int PA_W  = 12;
  localparam int NV    = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_valid = 1'b0;
  logic [SEG_W-1:0] cfg_idx = '0;
  logic [PA_W-1:0]  cfg_base = '0;
  logic [OFF_W:0]   cfg_len = '0;
  logic [2:0]       cfg_perm = '0;
  logic [SEG_W:0]   cfg_count = '0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic req_ready, rsp_valid;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_acc = '0;
  logic [PA_W-1:0]  rsp_paddr;
  logic [2:0]       rsp_fault;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_xlate_top #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_len(cfg_len), .cfg_valid(cfg_valid), .cfg_perm(cfg_perm), .cfg_count(cfg_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  // {seg, off, acc, expected fault, expected paddr}
  localparam logic [27:0] VEC [NV] = '{
    {3'd0, 8'h05, 2'd0, 3'd0, 12'h105},  // R1 read
    {3'd0, 8'h3F, 2'd2, 3'd0, 12'h13F},  // R1 exec at last byte
    {3'd0, 8'h40, 2'd0, 3'd3, 12'h000},  // R4 one past end
    {3'd0, 8'h00, 2'd1, 3'd4, 12'h000},  // R5 write not allowed
    {3'd1, 8'h0F, 2'd1, 3'd0, 12'h20F},  // R1 write
    {3'd1, 8'h10, 2'd2, 3'd3, 12'h000},  // R6 length beats permission
    {3'd1, 8'h02, 2'd2, 3'd4, 12'h000},  // R5 exec not allowed
    {3'd2, 8'h00, 2'd0, 3'd2, 12'h000},  // R3 invalid entry
    {3'd2, 8'hFF, 2'd2, 3'd2, 12'h000},  // R6 invalid beats length
    {3'd3, 8'h20, 2'd1, 3'd0, 12'h010},  // R1 wraps modulo 2^PA_W
    {3'd4, 8'h00, 2'd0, 3'd3, 12'h000},  // R4 empty segment
    {3'd5, 8'h00, 2'd0, 3'd1, 12'h000},  // R2 equal to count
    {3'd7, 8'h00, 2'd0, 3'd1, 12'h000},  // R2 far beyond count
    {3'd0, 8'h05, 2'd3, 3'd4, 12'h000}   // R5 reserved code
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_entry(input int idx, input int base, input int len, input bit v, input int perm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = SEG_W'(idx);
    cfg_base = PA_W'(base); cfg_len = (OFF_W+1)'(len); cfg_valid = v; cfg_perm = 3'(perm);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_count(input int c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_count = (SEG_W+1)'(c);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issue one request, then sample the response on the following negedge.
  task automatic xlate(input int seg, input int off, input int acc,
                       output logic [2:0] f, output logic [PA_W-1:0] pa);
    @(negedge clk);
    req_valid = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 rsp_valid", int'(rsp_valid), 1);
    f = rsp_fault; pa = rsp_paddr;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] f;
    logic [PA_W-1:0] pa;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rsp_valid after reset", int'(rsp_valid), 0);
    check("R9 req_ready idle", int'(req_ready), 1);

    // R10: count is 0 after reset, so even a configured entry faults.
    wr_entry(0, 'h100, 'h40, 1'b1, 3'b101);
    xlate(0, 5, 0, f, pa);
    check("R10 fault before count set", int'(f), 1);

    wr_entry(1, 'h200, 'h10,  1'b1, 3'b011);
    wr_entry(2, 'h300, 'h80,  1'b0, 3'b111);
    wr_entry(3, 'hFF0, 'h100, 1'b1, 3'b111);
    wr_entry(4, 'h050, 0,     1'b1, 3'b111);
    wr_entry(5, 'h400, 'h10,  1'b1, 3'b111);
    wr_count(5);

    for (int i = 0; i < NV; i++) begin
      xlate(int'(VEC[i][27:25]), int'(VEC[i][24:17]), int'(VEC[i][16:15]), f, pa);
      check($sformatf("R1-chain vec%0d fault (R2 R3 R4 R5 R6)", i), int'(f), int'(VEC[i][14:12]));
      check($sformatf("R7 vec%0d paddr", i), int'(pa), int'(VEC[i][11:0]));
    end

    // R9: back-pressure with a second request waiting.
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_seg = 3'd1; req_off = 8'h03; req_acc = 2'd0;
    @(negedge clk);
    req_seg = 3'd0; req_off = 8'h07; req_acc = 2'd0;
    for (int k = 0; k < 3; k++) begin
      check("R9 held valid", int'(rsp_valid), 1);
      check("R9 req_ready low", int'(req_ready), 0);
      check("R9 held paddr", int'(rsp_paddr), 'h203);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 waiting request paddr", int'(rsp_paddr), 'h107);
    @(negedge clk);
    check("R9 drained", int'(rsp_valid), 0);

    // R11: rewrite entry 1 on the same edge a request for it is taken.
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'd1; req_off = 8'h04; req_acc = 2'd0;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = 3'd1; cfg_base = 12'h500;
    cfg_len = 9'h10; cfg_valid = 1'b0; cfg_perm = 3'b011;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check("R11 old table fault", int'(rsp_fault), 0);
    check("R11 old table paddr", int'(rsp_paddr), 'h204);
    xlate(1, 4, 0, f, pa);
    check("R11 new entry seen", int'(f), 2);

    // R11: count write; segment 0 now out of range.
    wr_count(0);
    xlate(0, 5, 0, f, pa);
    check("R11 R2 count lowered", int'(f), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule